// File: doc/BRIEF.md
# Iterative Sine/Cosine Rotator with Quadrant Folding

This unit takes one signed angle, expressed as a fraction of a half turn, and returns its sine and cosine as signed fixed-point fractions. The angle is first folded into the range 0 to pi/2 by three magnitude comparisons. The fold that was chosen is held in a register. The folded angle is then multiplied by a constant, which turns half-turn units into radians in the internal fixed-point format.

A rotation-mode CORDIC loop then runs a fixed number of micro-rotations, one per clock cycle. Each step reads one arctangent constant from a table that is computed at elaboration. The x register starts at the inverse of the CORDIC gain and y starts at zero, so no scaling is needed at the end. After the last step, the stored fold is undone by swapping and negating the two results. The results are then rounded into registered outputs.

Control is a simple start/busy/done handshake. A new angle is accepted only while the unit is idle.

Top module: `cordic_sincos`

## Requirements
- R1: Reset, asynchronous and active low, clears `busy_o`, `done_o`, `sin_o` and `cos_o` to zero. A reset that arrives in the middle of a computation abandons it.
- R2: For an input a, where `angle_i` is a two's-complement number with AW-1 fraction bits, the outputs are sin(pi·a) and cos(pi·a). Each is a two's-complement number with OW-1 fraction bits (Q1.15 by default), within 4 LSB of the exact value.
- R3: The fold is chosen by range. For 0 <= a < 0.5 there is no offset. For a >= 0.5 the offset is +0.5, and the results are sine = cos(w), cosine = -sin(w). For -0.5 <= a < 0 the offset is -0.5, and the results are sine = -cos(w), cosine = sin(w). For a < -0.5 the offset is -1, and both results are negated. Here w = a - offset.
- R4: The boundary angles 0, +0.5, -0.5 and -1 each give exactly one of the values ±1 or 0 (within 4 LSB). A result of +1 saturates to 0x7FFF, and -1 is 0x8000.
- R5: `done_o` is high for exactly one cycle. It rises ITER+1 clock edges after the edge that accepted `start_i`.
- R6: `busy_o` is high from the edge after the accepting edge until the edge that raises `done_o`. It is low whenever `done_o` is high.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The current result, its timing and the single `done_o` pulse are unchanged.
- R8: `sin_o` and `cos_o` change only on the edge that raises `done_o`. They hold their values while idle and during the next computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a computation; sampled while idle |
| angle_i | input | AW | Angle, signed fraction of a half turn |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse: results updated |
| sin_o | output | OW | Sine, signed Q1.(OW-1) |
| cos_o | output | OW | Cosine, signed Q1.(OW-1) |

## Verification
A wrong fold register, or a wrong fold decision, does not show up as a small error. It shows up as swapped or sign-flipped results, in the first result after the bad state. The test angles therefore cover every range of R3 and every boundary of R4. A damaged table entry, gain constant or step counter shows up as an error well beyond the tolerance, or as a `done_o` that comes at the wrong cycle. The latency is checked on every computation, so these faults appear on the first `done_o`. A restart while busy, or outputs that move between results, show up as a wrong value or an extra pulse within one computation time.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

   typedef enum logic [1:0] {
      QD_0    = 2'd0,   // no fold
      QD_P90  = 2'd1,   // offset +half
      QD_M90  = 2'd2,   // offset -half
      QD_180  = 2'd3    // offset -one
   } quad_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROT  = 2'd1,
      ST_OUT  = 2'd2
   } state_e;

   // product of 1/sqrt(1+2^-2i) over the micro-rotations
   function automatic real inv_gain(input int n);
      real g;
      g = 1.0;
      for (int i = 0; i < n; i++) begin
         g = g / $sqrt(1.0 + 2.0 ** (-2 * i));
      end
      return g;
   endfunction

endpackage

// File: rtl/cordic_fold.sv
module cordic_fold
   import cordic_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic signed [AW-1:0] angle_i,
   output logic        [DW-1:0] z_o,
   output quad_e                quad_o
);
   localparam logic signed [AW-1:0] HALF_P = {2'b01, {(AW-2){1'b0}}};
   localparam logic signed [AW-1:0] HALF_N = {2'b11, {(AW-2){1'b0}}};
   localparam logic signed [AW-1:0] ONE_N  = {1'b1, {(AW-1){1'b0}}};
   // pi with DW-3 fraction bits
   localparam logic [DW-1:0] PI_C = DW'($rtoi(3.14159265358979 * (2.0 ** (DW - 3))));

   logic               ge_hi, ge_zero, ge_lo;
   logic signed [AW-1:0] offs;
   logic signed [AW:0]   w_wide;
   logic [AW-1:0]        w;
   logic [AW+DW-1:0]     prod;

   always_comb begin
      ge_hi   = (angle_i >= HALF_P);
      ge_zero = !angle_i[AW-1];
      ge_lo   = (angle_i >= HALF_N);
      if (ge_hi) begin
         quad_o = QD_P90;
         offs   = HALF_P;
      end else if (ge_zero) begin
         quad_o = QD_0;
         offs   = '0;
      end else if (ge_lo) begin
         quad_o = QD_M90;
         offs   = HALF_N;
      end else begin
         quad_o = QD_180;
         offs   = ONE_N;
      end
   end

   assign w_wide = {angle_i[AW-1], angle_i} - {offs[AW-1], offs};
   assign w      = w_wide[AW-1:0];
   // half-turn fraction (AW-1 frac) times pi (DW-3 frac) -> DW-2 frac
   assign prod   = {{DW{1'b0}}, w} * {{AW{1'b0}}, PI_C};
   assign z_o    = prod[AW-2 +: DW];

   logic unused_fold;
   assign unused_fold = ^{w_wide[AW], prod[AW+DW-1 -: 2], prod[AW-3:0]};

endmodule

// File: rtl/cordic_micro.sv
module cordic_micro #(
   parameter int DW   = 32,
   parameter int ITER = 16,
   parameter int KW   = 4
) (
   input  logic signed [DW-1:0] x_i,
   input  logic signed [DW-1:0] y_i,
   input  logic signed [DW-1:0] z_i,
   input  logic        [KW-1:0] k_i,
   output logic signed [DW-1:0] x_o,
   output logic signed [DW-1:0] y_o,
   output logic signed [DW-1:0] z_o
);
   localparam int FRAC = DW - 2;

   logic [DW-1:0] rom [ITER];

   for (genvar gk = 0; gk < ITER; gk++) begin : g_rom
      assign rom[gk] = DW'($rtoi($atan(2.0 ** (-gk)) * (2.0 ** FRAC)));
   end

   function automatic logic [DW-1:0] cneg(input logic [DW-1:0] v, input logic s);
      return (v ^ {DW{s}}) + DW'(s);
   endfunction

   logic                 d;
   logic signed [DW-1:0] xs, ys;
   logic        [DW-1:0] at;

   assign d   = z_i[DW-1];
   assign xs  = x_i >>> k_i;
   assign ys  = y_i >>> k_i;
   assign at  = rom[k_i];
   assign x_o = x_i - $signed(cneg(ys, d));
   assign y_o = y_i + $signed(cneg(xs, d));
   assign z_o = z_i - $signed(cneg(at, d));

endmodule

// File: rtl/cordic_unfold.sv
module cordic_unfold
   import cordic_pkg::*;
#(
   parameter int DW  = 32,
   parameter int OW  = 16,
   parameter bit RND = 1'b1
) (
   input  logic signed [DW-1:0] x_i,
   input  logic signed [DW-1:0] y_i,
   input  quad_e                quad_i,
   output logic signed [OW-1:0] sin_o,
   output logic signed [OW-1:0] cos_o
);
   localparam int SH = DW - 1 - OW;
   localparam logic signed [DW:0] BIAS = (DW+1)'(1) << (SH - 1);
   localparam logic signed [DW:0] MAXV = (DW+1)'((1 << (OW - 1)) - 1);
   localparam logic signed [DW:0] MINV = ~MAXV;

   logic signed [DW-1:0] pre  [2];
   logic signed [OW-1:0] post [2];

   always_comb begin
      case (quad_i)
         QD_P90: begin pre[0] = x_i;  pre[1] = -y_i; end
         QD_M90: begin pre[0] = -x_i; pre[1] = y_i;  end
         QD_180: begin pre[0] = -y_i; pre[1] = -x_i; end
         default: begin pre[0] = y_i; pre[1] = x_i;  end
      endcase
   end

   for (genvar c = 0; c < 2; c++) begin : g_ch
      logic signed [DW:0] t, r;
      if (RND) begin : g_rnd
         assign t = {pre[c][DW-1], pre[c]} + BIAS;
      end else begin : g_trn
         assign t = {pre[c][DW-1], pre[c]};
      end
      assign r = t >>> SH;
      assign post[c] = (r > MAXV) ? MAXV[OW-1:0] :
                       (r < MINV) ? MINV[OW-1:0] : r[OW-1:0];
   end

   assign sin_o = post[0];
   assign cos_o = post[1];

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
   import cordic_pkg::*;
#(
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int OW   = 16,
   parameter int ITER = 16,
   parameter bit RND  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic signed [AW-1:0] angle_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic signed [OW-1:0] sin_o,
   output logic signed [OW-1:0] cos_o
);
   localparam int KW = (ITER > 1) ? $clog2(ITER) : 1;
   localparam logic [DW-1:0] K_C = DW'($rtoi(inv_gain(ITER) * (2.0 ** (DW - 2))));

   if (ITER < 10 || ITER > DW - 2) begin : g_bad_iter
      $error("cordic_sincos: ITER must lie in 10..DW-2");
   end
   if (DW < 18 || DW > 32) begin : g_bad_dw
      $error("cordic_sincos: DW must lie in 18..32");
   end
   if (OW < 8 || OW > DW - 2) begin : g_bad_ow
      $error("cordic_sincos: OW must lie in 8..DW-2");
   end
   if (AW < 8) begin : g_bad_aw
      $error("cordic_sincos: AW must be at least 8");
   end

   state_e               st;
   quad_e                quad, fold_quad;
   logic signed [DW-1:0] x, y, z, x_n, y_n, z_n;
   logic        [DW-1:0] z0;
   logic        [KW-1:0] k;
   logic signed [OW-1:0] s_u, c_u;

   cordic_fold #(.AW(AW), .DW(DW)) u_fold (
      .angle_i(angle_i), .z_o(z0), .quad_o(fold_quad)
   );

   cordic_micro #(.DW(DW), .ITER(ITER), .KW(KW)) u_micro (
      .x_i(x), .y_i(y), .z_i(z), .k_i(k),
      .x_o(x_n), .y_o(y_n), .z_o(z_n)
   );

   cordic_unfold #(.DW(DW), .OW(OW), .RND(RND)) u_unfold (
      .x_i(x), .y_i(y), .quad_i(quad), .sin_o(s_u), .cos_o(c_u)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         quad   <= QD_0;
         x      <= '0;
         y      <= '0;
         z      <= '0;
         k      <= '0;
         sin_o  <= '0;
         cos_o  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start_i) begin
                  x    <= $signed(K_C);
                  y    <= '0;
                  z    <= $signed(z0);
                  quad <= fold_quad;
                  k    <= '0;
                  st   <= ST_ROT;
               end
            end
            ST_ROT: begin
               x <= x_n;
               y <= y_n;
               z <= z_n;
               k <= k + KW'(1);
               if (k == KW'(ITER - 1)) st <= ST_OUT;
            end
            ST_OUT: begin
               sin_o  <= s_u;
               cos_o  <= c_u;
               done_o <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (st != ST_IDLE);

endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
   parameter int OW   = 16,
   parameter int ITER = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic                 busy_o,
   input logic                 done_o,
   input logic signed [OW-1:0] sin_o,
   input logic signed [OW-1:0] cos_o
);
   // edges counted since the accepting edge
   logic [15:0] since;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since <= '0;
      else if (start_i && !busy_o) since <= '0;
      else if (busy_o)           since <= since + 16'd1;
   end

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (since == 16'(ITER + 1)));

   a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   a_r6_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r8_hold_sin: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(sin_o));

   a_r8_hold_cos: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(cos_o));

endmodule

bind cordic_sincos cordic_sincos_chk #(.OW(OW), .ITER(ITER)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
   .done_o(done_o), .sin_o(sin_o), .cos_o(cos_o)
);

// File: tb/sim_cordic_sincos.sv
module sim_cordic_sincos;
   localparam int ITER = 16;
   localparam int TOL  = 4;
   localparam int NV   = 13;

   localparam logic [31:0] V_ANG [NV] = '{
      32'h0000_0000, 32'h2000_0000, 32'h4000_0000, 32'h6000_0000,
      32'h8000_0000, 32'hC000_0000, 32'hE000_0000, 32'hA000_0000,
      32'h1555_5555, 32'h2AAA_AAAB, 32'h5555_5555, 32'hD555_5555,
      32'h7FFF_FFFF };
   localparam int V_SIN [NV] = '{
      0, 23170, 32767, 23170, 0, -32768, -23170, -23170,
      16384, 28378, 28378, -28378, 0 };
   localparam int V_COS [NV] = '{
      32767, 23170, 0, -23170, -32768, 0, 23170, -23170,
      28378, 16384, -16384, 16384, -32768 };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic signed [31:0] angle = '0;
   logic               busy, done;
   logic signed [15:0] s, c;
   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   cordic_sincos #(.ITER(ITER)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .angle_i(angle),
      .busy_o(busy), .done_o(done), .sin_o(s), .cos_o(c)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic near(input string req, input int act, input int exp);
      chk((act - exp) <= TOL && (exp - act) <= TOL, req, act, exp);
   endtask

   // drive start at a negedge; returns at the negedge after the accepting edge
   task automatic launch(input logic [31:0] a);
      @(negedge clk);
      angle = a;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(inout int cyc);
      while (!done && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done, "R1 reset flags", {busy, done}, 0);
      chk(s == 0 && c == 0, "R1 reset outputs", s, 0);
      rst_n = 1'b1;

      // R2 R3 R4: table walk, latency R5/R6 on each
      for (int i = 0; i < NV; i++) begin
         int cyc;
         launch(V_ANG[i]);
         cyc = 1;
         chk(busy, "R6 busy after accept", busy, 1);
         wait_done(cyc);
         // done appears after edge ITER+1 counted from the accepting edge
         chk(cyc == ITER + 2, "R5 latency", cyc, ITER + 2);
         chk(!busy, "R6 busy low with done", busy, 0);
         near($sformatf("R2/R3/R4 sin vec %0d", i), s, V_SIN[i]);
         near($sformatf("R2/R3/R4 cos vec %0d", i), c, V_COS[i]);
         @(negedge clk);
         chk(!done, "R5 single-cycle done", done, 0);
      end

      // R7: start while busy is ignored
      begin
         int cyc;
         launch(32'h2000_0000);
         cyc = 1;
         @(negedge clk); cyc++;
         @(negedge clk); cyc++;
         angle = 32'shC000_0000;
         start = 1'b1;
         @(negedge clk); cyc++;
         start = 1'b0;
         // R8: previous result still held mid-run
         near("R8 hold during run sin", s, V_SIN[12]);
         wait_done(cyc);
         chk(cyc == ITER + 2, "R7 latency unchanged", cyc, ITER + 2);
         near("R7 sin of first angle", s, 23170);
         near("R7 cos of first angle", c, 23170);
         for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk(!done && !busy, "R7 no second done", {busy, done}, 0);
         end
         near("R8 hold while idle sin", s, 23170);
         near("R8 hold while idle cos", c, 23170);
      end

      // R1: reset in mid-computation
      launch(32'h4000_0000);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy && !done, "R1 mid-run reset flags", {busy, done}, 0);
      chk(s == 0 && c == 0, "R1 mid-run reset outputs", c, 0);
      rst_n = 1'b1;
      repeat (ITER + 4) @(negedge clk);
      chk(!done && !busy, "R1 abandoned run stays idle", {busy, done}, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule